// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits on the controller side of an SDRAM interface and performs one read for each request. The row is assumed to be open already. A request names a bank, a start column, a word count, and two mode bits: full-page versus fixed-length burst, and auto precharge. The block puts a READ on the command bus. It then works out from the CAS latency the cycle in which a truncating command must reach the device, so that the last word the device drives is the last word that was asked for. Each wanted word is captured from the data bus after the CAS latency and handed out with a valid strobe. A one-cycle done pulse closes the request.

The truncating command depends on the mode:

- **Full-page bursts** are cut with a burst-stop command. If auto precharge was requested, a bank precharge is used instead, so the cut also closes the row.
- **Fixed-length bursts without auto precharge** are cut with burst-stop.
- **Fixed-length bursts with auto precharge** cannot be cut. The burst runs to its full length and the surplus words are captured but discarded.

The CAS latency (2 or 3) is a static setting that is sampled when a request is accepted. Only one request is in flight at a time.

Top module: `sdram_rd_trunc`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, cmd_op is NOP (0), rd_valid is 0 and done is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. In the next cycle cmd_op is READ (1), cmd_bank and cmd_col carry the request, and cmd_ap equals req_auto_pre AND NOT req_full_page. While busy, req_valid is ignored.
- R3: Let CL be 3 when cas_lat3 is 1, and 2 otherwise. Word k of the burst (column (col+k) mod 512) is captured CL+k cycles after the clock edge that samples the READ. rd_valid and rd_data present it in the following cycle, on consecutive cycles and in column order.
- R4: For a burst that is truncated with L wanted words, the truncating command is sampled L cycles after the READ edge. That is CL-1 cycles before the edge at which the last wanted word is valid, so the device drives exactly L words.
- R5: Choice of truncating command. Full page without auto precharge uses burst-stop (cmd_op 2). Full page with auto precharge uses precharge (cmd_op 3) on the same bank, with cmd_ap 0. Fixed length without auto precharge and L below 8 uses burst-stop.
- R6: For a fixed-length burst with auto precharge and L below 8, no burst-stop or precharge is issued. The full 8-word burst is awaited, and only the first L words raise rd_valid.
- R7: For a fixed-length burst, L is clamped to 8, and an 8-word request issues no truncating command. For a full-page burst, L is clamped to 512.
- R8: A word count of 0 is treated as 1.
- R9: busy is 1 from the cycle after acceptance until the last word of the burst window has been captured. done is a one-cycle pulse in the first cycle with busy low. rd_valid stays low after the last wanted word.
- R10: dq_mask is held at 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BANK_W | Bank to read |
| req_col | input | COL_W | Start column |
| req_len | input | COL_W+1 | Wanted word count |
| req_full_page | input | 1 | 1 = full-page burst, 0 = fixed length |
| req_auto_pre | input | 1 | Auto precharge requested |
| req_ready | output | 1 | Idle; a request can be taken |
| busy | output | 1 | Request in flight |
| cmd_op | output | 2 | 0 NOP, 1 READ, 2 burst-stop, 3 precharge |
| cmd_bank | output | BANK_W | Bank address for the command |
| cmd_col | output | COL_W | Column address for READ |
| cmd_ap | output | 1 | Auto-precharge flag with READ |
| dq_mask | output | 1 | Data mask, always low |
| dq_in | input | DATA_W | SDRAM read data |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| done | output | 1 | Request finished |

## Verification
Timing is measured from the cycle in which READ is visible, called c. The truncating command is due at c+L. Word k is due at c+1+CL+k. done and the fall of busy are due at c+CL+N, where N is the burst window (L, or 8 when surplus words are discarded).

The bench records the cycle number of every command, word and done pulse on the falling edge and compares each against these formulas. A behavioural device model drives only the words that the received command sequence permits. Comparing its driven-word count with L shows whether the terminate landed exactly on the last wanted word.

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc #(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [COL_W:0]    req_len,
  input  logic              req_full_page,
  input  logic              req_auto_pre,
  output logic              req_ready,
  output logic              busy,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  output logic              dq_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int LEN_W = COL_W + 1;
  localparam int CNT_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] PAGE = LEN_W'(1) << COL_W;
  localparam logic [LEN_W-1:0] BL   = LEN_W'(BURST_LEN);
  localparam logic [1:0] OP_NOP = 2'd0, OP_READ = 2'd1, OP_STOP = 2'd2, OP_PRE = 2'd3;

  logic [LEN_W-1:0] len1, cap, want, run, want_q, run_q;
  logic [1:0]       term, term_q;
  logic [CNT_W-1:0] cnt, cl, widx;
  logic             cl3_q, accept, capture, ap_seen;

  assign req_ready = !busy;
  assign dq_mask   = 1'b0;
  assign accept    = req_valid && !busy;

  assign len1 = (req_len == '0) ? LEN_W'(1) : req_len;
  assign cap  = req_full_page ? PAGE : BL;
  assign want = (len1 > cap) ? cap : len1;
  assign term = req_full_page ? (req_auto_pre ? OP_PRE : OP_STOP)
                              : ((want < BL && !req_auto_pre) ? OP_STOP : OP_NOP);
  assign run  = (!req_full_page && req_auto_pre) ? BL : want;

  assign cl      = cl3_q ? CNT_W'(3) : CNT_W'(2);
  assign widx    = cnt - cl;
  assign capture = busy && (cnt >= cl) && (widx < CNT_W'(run_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cl3_q    <= 1'b0;
      want_q   <= '0;
      run_q    <= '0;
      term_q   <= OP_NOP;
      cnt      <= '0;
      cmd_op   <= OP_NOP;
      cmd_bank <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        cl3_q    <= cas_lat3;
        want_q   <= want;
        run_q    <= run;
        term_q   <= term;
        cnt      <= '0;
        cmd_op   <= OP_READ;
        cmd_bank <= req_bank;
        cmd_col  <= req_col;
        cmd_ap   <= req_auto_pre && !req_full_page;
      end else if (busy) begin
        cnt     <= cnt + 1'b1;
        cmd_col <= '0;
        cmd_ap  <= 1'b0;
        cmd_op  <= (term_q != OP_NOP && cnt == CNT_W'(want_q) - 1'b1) ? term_q : OP_NOP;
        if (capture) begin
          rd_data  <= dq_in;
          rd_valid <= widx < CNT_W'(want_q);
          if (widx == CNT_W'(run_q) - 1'b1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ap_seen <= 1'b0;
    else if (cmd_op == OP_READ) ap_seen <= cmd_ap;
  end

  assert_no_stop_after_ap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_STOP) |-> !ap_seen);
  assert_idle_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_op == OP_NOP));
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_READ) |=> (cmd_op != OP_READ));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready));
  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_valid_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(busy));
endmodule

// File: tb/sim_sdram_rd_trunc.sv
module sim_sdram_rd_trunc;
  logic clk = 0, rst_n = 0;
  logic cas_lat3 = 0, req_valid = 0, req_full_page = 0, req_auto_pre = 0;
  logic [1:0] req_bank = 0;
  logic [8:0] req_col = 0;
  logic [9:0] req_len = 0;
  logic req_ready, busy, cmd_ap, dq_mask, rd_valid, done;
  logic [1:0] cmd_op, cmd_bank;
  logic [8:0] cmd_col;
  logic [15:0] dq_in = 16'hDEAD, rd_data;

  sdram_rd_trunc u0 (.clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .req_valid(req_valid),
    .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_full_page(req_full_page),
    .req_auto_pre(req_auto_pre), .req_ready(req_ready), .busy(busy), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .dq_mask(dq_mask), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [15:0] dval(int b, int c, int k);
    return 16'hA000 ^ 16'(b << 12) ^ 16'((c + k) % 512);
  endfunction

  // behavioural device: drives words only as the command sequence allows
  bit t_full = 0, t_cl3 = 0, m_on = 0, m_ap = 0;
  int mo = 0, mstop = 0, mdrv = 0, m_bad = 0, mbank = 0, mcol = 0;
  always @(posedge clk) begin
    int k, lim;
    cyc <= cyc + 1;
    if (cmd_op == 2'd1) begin
      m_on = 1; mo = 0; mbank = int'(cmd_bank); mcol = int'(cmd_col);
      m_ap = cmd_ap; mstop = 100000; mdrv = 0;
    end else if (m_on) mo = mo + 1;
    if (m_on && cmd_op >= 2'd2) begin
      mstop = mo;
      if (cmd_op == 2'd2 && !t_full && m_ap) m_bad++;
    end
    if (m_on) begin
      k = mo - (t_cl3 ? 2 : 1);
      lim = t_full ? 100000 : 8;
      if (k >= 0 && k < lim && k < mstop) begin dq_in <= dval(mbank, mcol, k); mdrv++; end
      else dq_in <= 16'hDEAD;
    end
  end

  // monitor at the falling edge
  bit mon = 0;
  int n_read, r_cyc, r_bank, r_col, r_ap, n_term, t_op, t_cyc, t_bank, t_ap;
  int w_n, d_cyc, n_done, n_mask, last_busy;
  logic [15:0] w_d [1024];
  int w_c [1024];
  always @(negedge clk) begin
    if (dq_mask) n_mask++;
    if (mon) begin
      if (cmd_op == 2'd1) begin
        n_read++; r_cyc = cyc; r_bank = int'(cmd_bank); r_col = int'(cmd_col); r_ap = int'(cmd_ap);
      end
      if (cmd_op >= 2'd2) begin
        n_term++; t_op = int'(cmd_op); t_cyc = cyc; t_bank = int'(cmd_bank); t_ap = int'(cmd_ap);
      end
      if (rd_valid && w_n < 1024) begin w_d[w_n] = rd_data; w_c[w_n] = cyc; w_n++; end
      if (done) begin n_done++; d_cyc = cyc; end
      if (busy) last_busy = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int bank, input int col, input int len, input bit full, input bit ap,
                          input bit cl3, input int ewords, input int erun, input int eterm, input bit poke);
    int cl, errs, to;
    cl = cl3 ? 3 : 2;
    @(negedge clk);
    n_read = 0; n_term = 0; w_n = 0; n_done = 0; last_busy = -1;
    t_full = full; t_cl3 = cl3; mon = 1;
    cas_lat3 = cl3; req_bank = 2'(bank); req_col = 9'(col); req_len = 10'(len);
    req_full_page = full; req_auto_pre = ap; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      req_col = 9'(col + 7); req_valid = 1;
      repeat (2) @(negedge clk);
      req_valid = 0;
    end
    to = 0;
    while (n_done == 0 && to < 3000) begin @(negedge clk); to++; end
    repeat (4) @(negedge clk);
    mon = 0;
    chk(n_read == 1, "R2", "read count", n_read, 1);
    chk(r_bank == bank && r_col == col, "R2", "read column", r_col, col);
    chk(r_ap == int'(ap && !full), "R2", "read ap flag", r_ap, int'(ap && !full));
    chk(w_n == ewords, "R3", "words returned", w_n, ewords);
    errs = 0;
    for (int i = 0; i < w_n; i++)
      if (w_d[i] != dval(bank, col, i) || w_c[i] != r_cyc + 1 + cl + i) errs++;
    chk(errs == 0, "R3", "word data/timing errors", errs, 0);
    if (eterm != 0) begin
      chk(n_term == 1 && t_op == eterm, "R5", "terminate opcode", t_op, eterm);
      chk(t_cyc == r_cyc + ewords, "R4", "terminate cycle offset", t_cyc - r_cyc, ewords);
      chk(mdrv == ewords, "R4", "words driven by device", mdrv, ewords);
      if (eterm == 3) chk(t_bank == bank && t_ap == 0, "R5", "precharge bank", t_bank, bank);
    end else begin
      chk(n_term == 0, "R6", "terminate commands (expect none)", n_term, 0);
      chk(mdrv == erun, "R7", "words driven by device", mdrv, erun);
    end
    chk(n_done == 1 && d_cyc == r_cyc + cl + erun, "R9", "done cycle offset", d_cyc - r_cyc, cl + erun);
    chk(last_busy == d_cyc - 1, "R9", "last busy cycle offset", last_busy - r_cyc, cl + erun - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && cmd_op == 0 && !rd_valid && !done, "R1", "reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && cmd_op == 0, "R1", "idle after reset", int'(cmd_op), 0);
    run_case(1,  16,   3, 0, 0, 0, 3,   3,   2, 0); // R4 R5 fixed cut, CL2
    run_case(2,  40,   3, 0, 0, 1, 3,   3,   2, 0); // R4 fixed cut, CL3
    run_case(0,   8,   1, 0, 0, 1, 1,   1,   2, 0); // R4 single word
    run_case(3, 500,  20, 1, 0, 1, 20,  20,  2, 0); // R5 full page, column wrap
    run_case(1, 100,   5, 1, 1, 0, 5,   5,   3, 0); // R5 precharge cut
    run_case(2,  24,   2, 0, 1, 0, 2,   8,   0, 0); // R6 discard surplus
    run_case(0,  32,   8, 0, 0, 1, 8,   8,   0, 0); // R7 full fixed burst
    run_case(3,  48,  12, 0, 0, 0, 8,   8,   0, 0); // R7 clamp to 8
    run_case(1,  64,   0, 0, 0, 0, 1,   1,   2, 0); // R8 zero length
    run_case(2,  72,   3, 0, 0, 1, 3,   3,   2, 1); // R2 request while busy ignored
    run_case(0,   3, 700, 1, 0, 0, 512, 512, 2, 0); // R7 full page clamp
    chk(m_bad == 0, "R6", "burst-stop after auto-precharge read", m_bad, 0);
    chk(n_mask == 0, "R10", "cycles with dq_mask high", n_mask, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule